// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the memory-mapped state store of a vectored interrupt controller. For each external interrupt it keeps an enable bit, a pending bit, an active bit, a target-non-secure bit and an 8-bit priority. A single-cycle register bus reaches this state through a byte offset and an access size of 1, 2 or 4 bytes. The decoder turns each access into a run of interrupt indices. In the bit-per-interrupt windows one data bit stands for one interrupt, so a byte step in the offset moves eight interrupts. In the priority window one data byte stands for one interrupt, so a byte step moves one interrupt.

Non-secure bus accesses are filtered per interrupt by its target-non-secure bit. Interrupt sources raise pending state through a request vector and drive active state through set and clear vectors. Arbitration between interrupts is handled elsewhere. This block only holds and exposes the state, as flat output vectors, to that logic.

Top module: `irq_regbank`

## Requirements
- R1: After reset every enable, pending, active, target-non-secure and priority bit is zero, and rsp_valid is low.
- R2: Every cycle with bus_valid high is followed, one cycle later, by exactly one cycle of rsp_valid high. rsp_rdata carries read data right-justified, with bits above the access width zero, and is zero for writes.
- R3: The bit-per-interrupt windows are set-enable 0x100–0x13F, clear-enable 0x180–0x1BF, set-pending 0x200–0x23F, clear-pending 0x280–0x2BF, active 0x300–0x33F and target-non-secure 0x380–0x3BF. Data bit j of an access at offset o maps to bank index 8*(o-base)+j, which is interrupt number FIRST_EXT plus that index. An access covers 8 times its byte count of interrupts.
- R4: Priorities occupy 0x400–0x5EF. Data byte j (bits 8j+7..8j) of an access at offset o maps to bank index (o-0x400)+j, and an access covers as many interrupts as it has bytes.
- R5: In a set window a written 1 sets the state bit, and in a clear window a written 1 clears it. A written 0 changes nothing. The set and clear windows of the same state read back identically.
- R6: Writes to the active window complete without error and change nothing. hw_act_set sets active bits and hw_act_clr clears them, with set winning when both are high.
- R7: hw_pend_set is OR-ed into the pending bits every cycle, and it wins over a bus clear of the same bit in the same cycle.
- R8: Bank indices at or above NUM_IRQ-FIRST_EXT read as zero and ignore writes, without an error.
- R9: A non-secure access (bus_secure=0) reads and writes an interrupt's bits or priority byte only when its target-non-secure bit is 1. Otherwise that interrupt reads zero and the write is ignored. Secure accesses reach all interrupts.
- R10: In the target-non-secure window a secure write stores each data bit (1 = non-secure target). A non-secure access there reads zero and its write is ignored.
- R11: An access with size code 3, an offset that is not a multiple of its byte count, or an offset outside every window returns rsp_err=1 with rsp_rdata zero and changes no state.
- R12: bus_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_secure | input | 1 | 1 = secure access |
| bus_offset | input | 12 | Byte offset of the access |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data, right-justified |
| hw_pend_set | input | NUM_IRQ-FIRST_EXT | Pending requests from sources |
| hw_act_set | input | NUM_IRQ-FIRST_EXT | Active set requests |
| hw_act_clr | input | NUM_IRQ-FIRST_EXT | Active clear requests |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access was rejected |
| irq_enable | output | NUM_IRQ-FIRST_EXT | Enable bits by bank index |
| irq_pending | output | NUM_IRQ-FIRST_EXT | Pending bits by bank index |
| irq_active | output | NUM_IRQ-FIRST_EXT | Active bits by bank index |
| irq_nonsec | output | NUM_IRQ-FIRST_EXT | Target-non-secure bits by bank index |
| irq_prio | output | 8*(NUM_IRQ-FIRST_EXT) | Priority byte k at bits 8k+7..8k |

## Verification
The assertions assume the bus inputs and source vectors are low while reset is held. They assume that a write to the active window can only be checked for "no change" in cycles where both active source vectors are idle. The stimulus keeps to these assumptions: it drives every input to zero through reset, and it never pulses hw_act_set or hw_act_clr in the same cycle as a bus access to the active window. Non-secure writes are issued only while no secure write to the target window is in flight, so the target bits stay quiet across them.

// File: rtl/irqrb_pkg.sv
package irqrb_pkg;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_EN_SET,
    WIN_EN_CLR,
    WIN_PD_SET,
    WIN_PD_CLR,
    WIN_ACT,
    WIN_NSEC,
    WIN_PRIO
  } win_e;

  localparam int unsigned IDX_W = 10;

  localparam logic [11:0] OFS_EN_SET = 12'h100;
  localparam logic [11:0] OFS_EN_CLR = 12'h180;
  localparam logic [11:0] OFS_PD_SET = 12'h200;
  localparam logic [11:0] OFS_PD_CLR = 12'h280;
  localparam logic [11:0] OFS_ACT    = 12'h300;
  localparam logic [11:0] OFS_NSEC   = 12'h380;
  localparam logic [11:0] OFS_PRIO   = 12'h400;
  localparam logic [11:0] OFS_PRIO_E = 12'h5EF;
  localparam logic [11:0] BITWIN_SPAN = 12'h040;

  typedef struct packed {
    win_e             win;
    logic             err;
    logic [IDX_W-1:0] first;
    logic [31:0]      dmask;
    logic [3:0]       bmask;
  } acc_t;

endpackage

// File: rtl/irqrb_rstsync.sv
module irqrb_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqrb_decode.sv
module irqrb_decode
  import irqrb_pkg::*;
(
  input  logic [11:0] offset,
  input  logic [1:0]  size,
  output acc_t        acc
);
  function automatic logic in_win(input logic [11:0] o, input logic [11:0] lo,
                                  input logic [11:0] hi);
    return (o >= lo) && (o <= hi);
  endfunction

  win_e win_d;
  logic unaligned;

  always_comb begin
    win_d = WIN_NONE;
    if      (in_win(offset, OFS_EN_SET, OFS_EN_SET + BITWIN_SPAN - 12'd1)) win_d = WIN_EN_SET;
    else if (in_win(offset, OFS_EN_CLR, OFS_EN_CLR + BITWIN_SPAN - 12'd1)) win_d = WIN_EN_CLR;
    else if (in_win(offset, OFS_PD_SET, OFS_PD_SET + BITWIN_SPAN - 12'd1)) win_d = WIN_PD_SET;
    else if (in_win(offset, OFS_PD_CLR, OFS_PD_CLR + BITWIN_SPAN - 12'd1)) win_d = WIN_PD_CLR;
    else if (in_win(offset, OFS_ACT,    OFS_ACT    + BITWIN_SPAN - 12'd1)) win_d = WIN_ACT;
    else if (in_win(offset, OFS_NSEC,   OFS_NSEC   + BITWIN_SPAN - 12'd1)) win_d = WIN_NSEC;
    else if (in_win(offset, OFS_PRIO,   OFS_PRIO_E))                       win_d = WIN_PRIO;
  end

  always_comb begin
    unaligned = 1'b0;
    acc.dmask = 32'h0;
    acc.bmask = 4'h0;
    unique case (size)
      2'd0: begin acc.dmask = 32'h0000_00FF; acc.bmask = 4'b0001; end
      2'd1: begin acc.dmask = 32'h0000_FFFF; acc.bmask = 4'b0011; unaligned = offset[0]; end
      2'd2: begin acc.dmask = 32'hFFFF_FFFF; acc.bmask = 4'b1111; unaligned = |offset[1:0]; end
      default: unaligned = 1'b1;
    endcase
    acc.win   = win_d;
    acc.err   = unaligned || (win_d == WIN_NONE);
    // bit windows: eight interrupts per byte; priority window: one per byte
    if (win_d == WIN_PRIO) acc.first = IDX_W'(offset - OFS_PRIO);
    else                   acc.first = {1'b0, offset[5:0], 3'b000};
  end
endmodule

// File: rtl/irqrb_bitreg.sv
module irqrb_bitreg #(
  parameter int unsigned N = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] bus_set,
  input  logic [N-1:0] bus_clr,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] hw_clr,
  output logic [N-1:0] q
);
  logic [N-1:0] d;
  logic         upd;

  always_comb begin
    d   = (((q & ~bus_clr) | bus_set) & ~hw_clr) | hw_set;
    upd = |{bus_set, bus_clr, hw_set, hw_clr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end

  // R7: a source set always lands, whatever the bus does
  p_hwset_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));

  // R6: a source clear without a source set drops the bit
  p_hwclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_clr & ~hw_set)) |=> ((q & $past(hw_clr & ~hw_set)) == '0));
endmodule

// File: rtl/irqrb_prio.sv
module irqrb_prio #(
  parameter int unsigned N = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   we,
  input  logic [N*8-1:0] wb,
  output logic [N*8-1:0] q
);
  logic [N*8-1:0] d;

  always_comb begin
    d = q;
    for (int k = 0; k < int'(N); k++) begin
      if (we[k]) d[k*8 +: 8] = wb[k*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (|we)  q <= d;
  end

  // R4: priority bytes hold without a write strobe
  p_prio_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|we) |=> $stable(q));
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irqrb_pkg::*;
#(
  parameter int unsigned FIRST_EXT = 16,
  parameter int unsigned NUM_IRQ   = 64
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_valid,
  input  logic                                 bus_write,
  input  logic                                 bus_secure,
  input  logic [11:0]                          bus_offset,
  input  logic [1:0]                           bus_size,
  input  logic [31:0]                          bus_wdata,
  input  logic [NUM_IRQ-FIRST_EXT-1:0]         hw_pend_set,
  input  logic [NUM_IRQ-FIRST_EXT-1:0]         hw_act_set,
  input  logic [NUM_IRQ-FIRST_EXT-1:0]         hw_act_clr,
  output logic                                 rsp_valid,
  output logic [31:0]                          rsp_rdata,
  output logic                                 rsp_err,
  output logic [NUM_IRQ-FIRST_EXT-1:0]         irq_enable,
  output logic [NUM_IRQ-FIRST_EXT-1:0]         irq_pending,
  output logic [NUM_IRQ-FIRST_EXT-1:0]         irq_active,
  output logic [NUM_IRQ-FIRST_EXT-1:0]         irq_nonsec,
  output logic [(NUM_IRQ-FIRST_EXT)*8-1:0]     irq_prio
);
  localparam int unsigned NB = NUM_IRQ - FIRST_EXT;
  localparam int unsigned PW = NB * 8;

  logic rst_sync_n;
  acc_t acc;

  irqrb_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));
  irqrb_decode  u_dec (.offset(bus_offset), .size(bus_size), .acc(acc));

  logic [NB-1:0] en_q, pd_q, act_q, ns_q;
  logic [PW-1:0] prio_q;
  logic [NB-1:0] perm, hitb, hity, wbits, wm;
  logic [NB-1:0] en_set, en_clr, pd_set, pd_clr, ns_set, ns_clr, prio_we;
  logic [PW-1:0] prio_wb, vis_prio;
  logic          wr_go;

  // lane alignment: data bit j lands on index first+j
  always_comb begin
    wr_go   = bus_valid & bus_write & ~acc.err;
    perm    = {NB{bus_secure}} | ((acc.win == WIN_NSEC) ? '0 : ns_q);
    hitb    = NB'({{NB{1'b0}}, acc.dmask} << acc.first);
    hity    = NB'({{NB{1'b0}}, acc.bmask} << acc.first);
    wbits   = NB'({{NB{1'b0}}, bus_wdata} << acc.first);
    prio_wb = PW'({{PW{1'b0}}, bus_wdata} << {acc.first, 3'b000});
    wm      = hitb & perm & {NB{wr_go}};
  end

  always_comb begin
    en_set  = '0; en_clr = '0; pd_set = '0; pd_clr = '0;
    ns_set  = '0; ns_clr = '0; prio_we = '0;
    unique case (acc.win)
      WIN_EN_SET: en_set  = wm & wbits;
      WIN_EN_CLR: en_clr  = wm & wbits;
      WIN_PD_SET: pd_set  = wm & wbits;
      WIN_PD_CLR: pd_clr  = wm & wbits;
      WIN_NSEC: begin
        ns_set = wm & wbits;
        ns_clr = wm & ~wbits;
      end
      WIN_PRIO:   prio_we = hity & perm & {NB{wr_go}};
      default: ;
    endcase
  end

  irqrb_bitreg #(.N(NB)) u_en (.clk(clk), .rst_n(rst_sync_n), .bus_set(en_set),
    .bus_clr(en_clr), .hw_set('0), .hw_clr('0), .q(en_q));
  irqrb_bitreg #(.N(NB)) u_pd (.clk(clk), .rst_n(rst_sync_n), .bus_set(pd_set),
    .bus_clr(pd_clr), .hw_set(hw_pend_set), .hw_clr('0), .q(pd_q));
  irqrb_bitreg #(.N(NB)) u_act (.clk(clk), .rst_n(rst_sync_n), .bus_set('0),
    .bus_clr('0), .hw_set(hw_act_set), .hw_clr(hw_act_clr), .q(act_q));
  irqrb_bitreg #(.N(NB)) u_ns (.clk(clk), .rst_n(rst_sync_n), .bus_set(ns_set),
    .bus_clr(ns_clr), .hw_set('0), .hw_clr('0), .q(ns_q));
  irqrb_prio   #(.N(NB)) u_prio (.clk(clk), .rst_n(rst_sync_n), .we(prio_we),
    .wb(prio_wb), .q(prio_q));

  // read path
  logic [NB-1:0] src;
  logic [31:0]   rd_bit, rd_pri, rd_d;

  always_comb begin
    for (int k = 0; k < int'(NB); k++) begin
      vis_prio[k*8 +: 8] = perm[k] ? prio_q[k*8 +: 8] : 8'h00;
    end
    unique case (acc.win)
      WIN_EN_SET, WIN_EN_CLR: src = en_q;
      WIN_PD_SET, WIN_PD_CLR: src = pd_q;
      WIN_ACT:                src = act_q;
      WIN_NSEC:               src = ns_q;
      default:                src = '0;
    endcase
    rd_bit = 32'({32'h0, src & perm} >> acc.first);
    rd_pri = 32'({32'h0, vis_prio} >> {acc.first, 3'b000});
    if (bus_valid && !bus_write && !acc.err)
      rd_d = ((acc.win == WIN_PRIO) ? rd_pri : rd_bit) & acc.dmask;
    else
      rd_d = 32'h0;
  end

  logic        rsp_valid_q, rsp_err_q;
  logic [31:0] rsp_rdata_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= bus_valid;
      rsp_err_q   <= bus_valid & acc.err;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    rsp_rdata_q <= 32'h0;
    else if (bus_valid) rsp_rdata_q <= rd_d;
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_err     = rsp_err_q;
  assign rsp_rdata   = rsp_rdata_q;
  assign irq_enable  = en_q;
  assign irq_pending = pd_q;
  assign irq_active  = act_q;
  assign irq_nonsec  = ns_q;
  assign irq_prio    = prio_q;

  // R2: one response per request, one cycle later
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_valid |=> rsp_valid);
  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_valid |=> !rsp_valid);
  // R2: a single-byte read never fills the upper lanes
  p_byte_read_narrow_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && !bus_write && bus_size == 2'd0) |=> (rsp_rdata[31:8] == 24'h0));
  // R11: rejected access carries zero data and leaves the enables alone
  p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));
  p_err_nochange_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && acc.err) |=> ($stable(en_q) && $stable(prio_q)));
  // R6: bus writes to the active window leave it untouched
  p_act_ro_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && bus_write && acc.win == WIN_ACT && hw_act_set == '0 && hw_act_clr == '0)
      |=> $stable(act_q));
  // R10: non-secure writes never move the target bits
  p_ns_guard_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && bus_write && !bus_secure) |=> $stable(ns_q));
endmodule

// File: tb/sim_irq_regbank.sv
`timescale 1ns/1ps
module sim_irq_regbank;
  localparam int NB = 48;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write, bus_secure;
  logic [11:0]   bus_offset;
  logic [1:0]    bus_size;
  logic [31:0]   bus_wdata;
  logic [NB-1:0] hw_pend_set, hw_act_set, hw_act_clr;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic [NB-1:0] irq_enable, irq_pending, irq_active, irq_nonsec;
  logic [NB*8-1:0] irq_prio;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int cyc   = 0;

  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];

  irq_regbank #(.FIRST_EXT(16), .NUM_IRQ(64)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_secure(bus_secure), .bus_offset(bus_offset), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .hw_pend_set(hw_pend_set), .hw_act_set(hw_act_set),
    .hw_act_clr(hw_act_clr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .irq_enable(irq_enable), .irq_pending(irq_pending),
    .irq_active(irq_active), .irq_nonsec(irq_nonsec), .irq_prio(irq_prio));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access, expectation pushed to the scoreboard
  task automatic bus_op(input bit wr, input bit sec, input logic [11:0] off,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input logic [31:0] exp_d, input bit exp_e, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_secure = sec;
    bus_offset = off; bus_size = sz; bus_wdata = wd;
    q_data.push_back(exp_d); q_err.push_back(exp_e); q_tag.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = 32'h0;
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (q_data.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        logic [31:0] ed;
        logic        ee;
        string       et;
        ed = q_data.pop_front(); ee = q_err.pop_front(); et = q_tag.pop_front();
        chk({et, " rdata"}, {32'h0, rsp_rdata}, {32'h0, ed});
        chk({et, " err"}, {63'h0, rsp_err}, {63'h0, ee});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_valid = 0; bus_write = 0; bus_secure = 0; bus_offset = '0; bus_size = '0;
    bus_wdata = '0; hw_pend_set = '0; hw_act_set = '0; hw_act_clr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
    chk("R1 state", {irq_enable | irq_pending | irq_active | irq_nonsec}, 64'h0);
    chk("R1 prio", {63'h0, |irq_prio}, 64'h0);

    // R3 R5 R12 enable set/clear windows
    bus_op(1, 1, 12'h100, 2'd2, 32'hF0F0_0001, 32'h0, 0, "R5 set-enable write");
    chk("R3 enable map", {16'h0, irq_enable}, 64'h0000_0000_F0F0_0001);
    bus_op(0, 1, 12'h180, 2'd2, 32'h0, 32'hF0F0_0001, 0, "R5 clear window reads same");
    bus_op(0, 1, 12'h103, 2'd0, 32'h0, 32'h0000_00F0, 0, "R3 R12 byte 3 lanes 24..31");
    bus_op(0, 1, 12'h101, 2'd0, 32'h0, 32'h0000_0000, 0, "R3 byte 1 lanes 8..15");
    bus_op(1, 1, 12'h180, 2'd0, 32'h0000_0001, 32'h0, 0, "R5 clear-enable write");
    chk("R5 clear one bit", {16'h0, irq_enable}, 64'h0000_0000_F0F0_0000);

    // R8 beyond the configured count
    bus_op(1, 1, 12'h104, 2'd2, 32'hFFFF_FFFF, 32'h0, 0, "R8 write past end");
    chk("R8 upper enables", {16'h0, irq_enable}, 64'h0000_FFFF_F0F0_0000);
    bus_op(0, 1, 12'h104, 2'd2, 32'h0, 32'h0000_FFFF, 0, "R8 read past end");
    bus_op(0, 1, 12'h106, 2'd1, 32'h0, 32'h0, 0, "R8 read fully past end");

    // R11 errors
    bus_op(1, 1, 12'h102, 2'd2, 32'hFFFF_FFFF, 32'h0, 1, "R11 unaligned write");
    bus_op(0, 1, 12'h100, 2'd3, 32'h0, 32'h0, 1, "R11 size code 3");
    bus_op(0, 1, 12'h000, 2'd0, 32'h0, 32'h0, 1, "R11 below windows");
    bus_op(0, 1, 12'h3C0, 2'd0, 32'h0, 32'h0, 1, "R11 gap");
    bus_op(0, 1, 12'h5F0, 2'd0, 32'h0, 32'h0, 1, "R11 past priority");
    chk("R11 no change", {16'h0, irq_enable}, 64'h0000_FFFF_F0F0_0000);

    // R4 priority bytes
    bus_op(1, 1, 12'h400, 2'd2, 32'h4433_2211, 32'h0, 0, "R4 prio write");
    chk("R4 prio bytes 0..3", {32'h0, irq_prio[31:0]}, 64'h4433_2211);
    bus_op(0, 1, 12'h401, 2'd0, 32'h0, 32'h22, 0, "R4 prio byte 1");
    bus_op(1, 1, 12'h42E, 2'd1, 32'h0000_BBAA, 32'h0, 0, "R4 prio halfword");
    bus_op(0, 1, 12'h42C, 2'd2, 32'h0, 32'hBBAA_0000, 0, "R4 prio read 44..47");
    bus_op(1, 1, 12'h430, 2'd0, 32'h77, 32'h0, 0, "R8 prio past end");
    bus_op(0, 1, 12'h430, 2'd0, 32'h0, 32'h0, 0, "R8 prio past end reads 0");
    bus_op(0, 1, 12'h5EC, 2'd2, 32'h0, 32'h0, 0, "R8 last prio word");

    // R6 active
    bus_op(1, 1, 12'h300, 2'd2, 32'hFFFF_FFFF, 32'h0, 0, "R6 active write ignored");
    chk("R6 active unchanged", {16'h0, irq_active}, 64'h0);
    hw_act_set = 48'h20;
    @(negedge clk); hw_act_set = '0;
    chk("R6 hw active set", {16'h0, irq_active}, 64'h20);
    bus_op(0, 1, 12'h300, 2'd0, 32'h0, 32'h20, 0, "R6 active read");
    hw_act_clr = 48'h20;
    @(negedge clk); hw_act_clr = '0;
    chk("R6 hw active clear", {16'h0, irq_active}, 64'h0);

    // R7 pending
    hw_pend_set = 48'h8;
    @(negedge clk); hw_pend_set = '0;
    chk("R7 hw pend", {16'h0, irq_pending}, 64'h8);
    bus_op(1, 1, 12'h280, 2'd0, 32'h08, 32'h0, 0, "R5 clear pending");
    chk("R5 pending cleared", {16'h0, irq_pending}, 64'h0);
    hw_pend_set = 48'h8;
    bus_op(1, 1, 12'h280, 2'd0, 32'h08, 32'h0, 0, "R7 clear vs hw set");
    hw_pend_set = '0;
    chk("R7 hw set wins", {16'h0, irq_pending}, 64'h8);
    bus_op(1, 1, 12'h200, 2'd1, 32'h0000_0200, 32'h0, 0, "R5 set pending");
    bus_op(0, 1, 12'h280, 2'd1, 32'h0, 32'h0208, 0, "R5 pending read clear window");

    // R9 R10 security
    bus_op(0, 0, 12'h100, 2'd2, 32'h0, 32'h0, 0, "R9 ns read all secure");
    bus_op(1, 1, 12'h380, 2'd2, 32'h00F0_0000, 32'h0, 0, "R10 target write");
    chk("R10 target bits", {16'h0, irq_nonsec}, 64'h0000_0000_00F0_0000);
    bus_op(0, 0, 12'h100, 2'd2, 32'h0, 32'h00F0_0000, 0, "R9 ns read masked");
    bus_op(1, 0, 12'h180, 2'd2, 32'hFFFF_FFFF, 32'h0, 0, "R9 ns clear-enable");
    chk("R9 ns clear masked", {16'h0, irq_enable}, 64'h0000_FFFF_F000_0000);
    bus_op(1, 0, 12'h400, 2'd2, 32'hFFFF_FFFF, 32'h0, 0, "R9 ns prio write secure irqs");
    chk("R9 prio unchanged", {32'h0, irq_prio[31:0]}, 64'h4433_2211);
    bus_op(1, 0, 12'h414, 2'd0, 32'h5A, 32'h0, 0, "R9 ns prio write");
    chk("R9 prio 20", {56'h0, irq_prio[167:160]}, 64'h5A);
    bus_op(0, 0, 12'h414, 2'd0, 32'h0, 32'h5A, 0, "R9 ns prio read");
    bus_op(0, 0, 12'h400, 2'd0, 32'h0, 32'h0, 0, "R9 ns prio read hidden");
    bus_op(1, 0, 12'h380, 2'd2, 32'hFFFF_FFFF, 32'h0, 0, "R10 ns target write");
    chk("R10 target kept", {16'h0, irq_nonsec}, 64'h0000_0000_00F0_0000);
    bus_op(0, 0, 12'h380, 2'd2, 32'h0, 32'h0, 0, "R10 ns target read");
    bus_op(0, 1, 12'h380, 2'd2, 32'h0, 32'h00F0_0000, 0, "R10 secure target read");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", {32'h0, 32'(q_data.size())}, 64'h0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule